// File: doc/BRIEF.md
# Linked-History Stride Prefetch Engine

The engine watches a stream of cache accesses. Each access carries a program counter and a cacheline address. It suggests cachelines worth fetching ahead of demand. An index table, addressed by a fold of the PC, points at the newest entry for that slot in a circular, time-ordered history buffer. Each history entry records a line address and a link back to the older entry that used the same index slot. Every accepted access is appended to the history. The engine then follows the links to recover the two previous addresses for the slot. If both deltas between the three addresses are equal and non-zero, it issues a burst of prefetch line addresses.

The burst starts `lookahead` strides past the current address and contains `degree` requests spaced one stride apart. The requests leave through a valid/ready port, one per cycle. A controller can retune lookahead and degree at any time through input ports. The engine captures both values when an access is accepted. While a burst is still draining, the access input holds its ready low, so no access is lost.

Top module: `historyStridePrefetcher`

## Requirements
- R1: After reset `pfValid` is 0, `accReady` is 1, and every index slot has no history.
- R2: The index slot is the XOR of the four bytes of the 32-bit PC. Different PCs with the same slot share one history chain, and PCs with different slots never interact.
- R3: Every accepted access (`accValid` and `accReady` both 1) is appended to the history. The first two accesses of a slot never trigger a burst.
- R4: A burst starts only when, for current address A and the two previous addresses P1 and P2 of the slot (P1 the newer), A−P1 equals P1−P2.
- R5: A stride of zero never starts a burst, and two consecutive requests of a burst never carry the same line.
- R6: A burst for stride d holds `degree` requests A+(l)d, A+(l+1)d, … in that order, with all arithmetic modulo 2^26. The first request is valid in the cycle after the access is accepted.
- R7: While `pfValid` is 1 and `pfReady` is 0, `pfValid` stays 1 and `pfLine` keeps its value.
- R8: `accReady` is 0 while any request of a burst is outstanding. It returns to 1 in the cycle after the last request is taken.
- R9: Lookahead and degree are captured when the triggering access is accepted. Later changes do not affect the burst. A degree of 0 produces no burst.
- R10: The history holds 256 entries. A link to an entry written more than 256 accesses before the current one is broken and prevents a burst. An entry written exactly 256 accesses earlier is still usable.
- R11: Negative strides work through modular subtraction of line addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLookahead | input | 3 | Strides to skip before the first request |
| cfgDegree | input | 3 | Number of requests per burst |
| accValid | input | 1 | Access present |
| accReady | output | 1 | Access can be taken this cycle |
| accPc | input | 32 | Program counter of the access |
| accLine | input | 26 | Cacheline address of the access |
| pfValid | output | 1 | Prefetch request present |
| pfReady | input | 1 | Consumer takes the request |
| pfLine | output | 26 | Prefetch cacheline address |

## Verification
The assertions check every cycle that a held request keeps its line and its valid, and that input ready stays low under back-pressure. They also check that a burst can only begin right after an accepted access, and that successive requests always advance. Whether the right slot chain was followed, the exact addresses, the capture of lookahead and degree, and the 256-versus-257 age boundary of a link can only be shown by the bench scenarios. These scenarios are compared against a behavioural model of the access history.

// File: rtl/hsPkg.sv
package hsPkg;
  typedef struct packed {
    logic insert;      // append the accepted access to the history
    logic startBurst;  // load the first prefetch line and the stride
    logic stepBurst;   // advance to the next prefetch line
  } hsStrobes_t;
endpackage

// File: rtl/hsDatapath.sv
module hsDatapath
  import hsPkg::*;
#(
  parameter int PC_W       = 32,
  parameter int LINE_W     = 26,
  parameter int IT_IDX_W   = 8,
  parameter int HIST_IDX_W = 8,
  parameter int SEQ_W      = 16,
  parameter int LA_W       = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  hsStrobes_t        strobes,
  input  logic [PC_W-1:0]   accPc,
  input  logic [LINE_W-1:0] accLine,
  input  logic [LA_W-1:0]   cfgLookahead,
  output logic              trigger,
  output logic [LINE_W-1:0] pfLine
);
  localparam int IT_DEPTH   = 1 << IT_IDX_W;
  localparam int HIST_DEPTH = 1 << HIST_IDX_W;
  localparam int FOLDS      = PC_W / IT_IDX_W;

  logic                  itValid   [IT_DEPTH];
  logic [SEQ_W-1:0]      itPtr     [IT_DEPTH];
  logic [LINE_W-1:0]     histLine  [HIST_DEPTH];
  logic [SEQ_W-1:0]      histPrev  [HIST_DEPTH];
  logic                  histPrevOk[HIST_DEPTH];
  logic [SEQ_W-1:0]      histSeq   [HIST_DEPTH];
  logic [SEQ_W-1:0]      headSeq;
  logic [LINE_W-1:0]     strideReg;

  logic [IT_IDX_W-1:0]   itSlot;
  logic [SEQ_W-1:0]      ptrNew, ptrOld;
  logic [HIST_IDX_W-1:0] slotNew, slotOld, headSlot;
  logic                  linkNewOk, linkOldOk;
  logic [LINE_W-1:0]     strideNew, strideOld;

  always_comb begin
    itSlot = '0;
    for (int k = 0; k < FOLDS; k++) itSlot ^= accPc[k*IT_IDX_W +: IT_IDX_W];
  end

  assign headSlot  = headSeq[HIST_IDX_W-1:0];
  assign ptrNew    = itPtr[itSlot];
  assign slotNew   = ptrNew[HIST_IDX_W-1:0];
  assign linkNewOk = itValid[itSlot] && (histSeq[slotNew] == ptrNew);
  assign ptrOld    = histPrev[slotNew];
  assign slotOld   = ptrOld[HIST_IDX_W-1:0];
  assign linkOldOk = linkNewOk && histPrevOk[slotNew] && (histSeq[slotOld] == ptrOld);
  assign strideNew = accLine - histLine[slotNew];
  assign strideOld = histLine[slotNew] - histLine[slotOld];
  assign trigger   = linkOldOk && (strideNew == strideOld) && (strideNew != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < IT_DEPTH; k++) itValid[k] <= 1'b0;
      headSeq <= '0;
    end else if (strobes.insert) begin
      itValid[itSlot] <= 1'b1;
      itPtr[itSlot]   <= headSeq;
      headSeq         <= headSeq + SEQ_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.insert) begin
      histLine[headSlot]   <= accLine;
      histPrev[headSlot]   <= ptrNew;
      histPrevOk[headSlot] <= itValid[itSlot];
      histSeq[headSlot]    <= headSeq;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pfLine    <= '0;
      strideReg <= '0;
    end else if (strobes.startBurst) begin
      pfLine    <= accLine + strideNew * LINE_W'(cfgLookahead);
      strideReg <= strideNew;
    end else if (strobes.stepBurst) begin
      pfLine <= pfLine + strideReg;
    end
  end

  // R5: a step always moves to a different line
  assert_step_advances_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stepBurst && !strobes.startBurst |=> pfLine != $past(pfLine));
endmodule

// File: rtl/hsControl.sv
module hsControl
  import hsPkg::*;
#(
  parameter int DEG_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accValid,
  input  logic             trigger,
  input  logic [DEG_W-1:0] cfgDegree,
  input  logic             pfReady,
  output logic             accReady,
  output logic             pfValid,
  output hsStrobes_t       strobes
);
  logic [DEG_W-1:0] remain;
  logic             accept;

  assign accReady = (remain == '0);
  assign pfValid  = (remain != '0);
  assign accept   = accValid && accReady;

  always_comb begin
    strobes.insert     = accept;
    strobes.startBurst = accept && trigger && (cfgDegree != '0);
    strobes.stepBurst  = pfValid && pfReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) remain <= '0;
    else if (strobes.startBurst) remain <= cfgDegree;
    else if (strobes.stepBurst) remain <= remain - DEG_W'(1);
  end

  // R7: a request not taken stays offered
  assert_hold_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    pfValid && !pfReady |=> pfValid);
  // R8: no access accepted while a request waits
  assert_stall_input_R8: assert property (@(posedge clk) disable iff (!rstN)
    pfValid && !pfReady |=> !accReady);
endmodule

// File: rtl/historyStridePrefetcher.sv
module historyStridePrefetcher
  import hsPkg::*;
#(
  parameter int PC_W       = 32,
  parameter int LINE_W     = 26,
  parameter int IT_IDX_W   = 8,
  parameter int HIST_IDX_W = 8,
  parameter int SEQ_W      = 16,
  parameter int LA_W       = 3,
  parameter int DEG_W      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LA_W-1:0]   cfgLookahead,
  input  logic [DEG_W-1:0]  cfgDegree,
  input  logic              accValid,
  output logic              accReady,
  input  logic [PC_W-1:0]   accPc,
  input  logic [LINE_W-1:0] accLine,
  output logic              pfValid,
  input  logic              pfReady,
  output logic [LINE_W-1:0] pfLine
);
  hsStrobes_t strobes;
  logic       trigger;

  hsControl #(.DEG_W(DEG_W)) i_control (
    .clk(clk), .rstN(rstN), .accValid(accValid), .trigger(trigger),
    .cfgDegree(cfgDegree), .pfReady(pfReady), .accReady(accReady),
    .pfValid(pfValid), .strobes(strobes)
  );

  hsDatapath #(
    .PC_W(PC_W), .LINE_W(LINE_W), .IT_IDX_W(IT_IDX_W),
    .HIST_IDX_W(HIST_IDX_W), .SEQ_W(SEQ_W), .LA_W(LA_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .accPc(accPc),
    .accLine(accLine), .cfgLookahead(cfgLookahead), .trigger(trigger),
    .pfLine(pfLine)
  );

  // R7: the offered line is stable under back-pressure
  assert_hold_line_R7: assert property (@(posedge clk) disable iff (!rstN)
    pfValid && !pfReady |=> $stable(pfLine));
  // R6: a burst only begins after an accepted access
  assert_burst_origin_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pfValid) |-> $past(accValid && accReady));
endmodule

// File: tb/test_historyStridePrefetcher.sv
module test_historyStridePrefetcher;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  cfgLookahead = 3'd4;
  logic [2:0]  cfgDegree = 3'd4;
  logic        accValid = 1'b0;
  logic        accReady;
  logic [31:0] accPc = '0;
  logic [25:0] accLine = '0;
  logic        pfValid;
  logic        pfReady = 1'b1;
  logic [25:0] pfLine;

  int    compared = 0;
  int    mismatched = 0;
  string curReq = "R1";
  bit    stallMode = 1'b0;
  bit    finished = 1'b0;

  always #4 clk = ~clk;

  historyStridePrefetcher i_historyStridePrefetcher (
    .clk(clk), .rstN(rstN), .cfgLookahead(cfgLookahead), .cfgDegree(cfgDegree),
    .accValid(accValid), .accReady(accReady), .accPc(accPc), .accLine(accLine),
    .pfValid(pfValid), .pfReady(pfReady), .pfLine(pfLine)
  );

  // behavioural reference: full access log plus a queue of pending requests
  typedef struct { int slot; logic [25:0] line; } rec_t;
  rec_t        hist[$];
  logic [25:0] pend[$];

  function automatic int foldPc(logic [31:0] pc);
    return int'(pc[7:0] ^ pc[15:8] ^ pc[23:16] ^ pc[31:24]);
  endfunction

  function automatic void modelAccess(logic [31:0] pc, logic [25:0] line,
                                      logic [2:0] la, logic [2:0] deg);
    int h = hist.size();
    int s = foldPc(pc);
    int i = -1;
    int j = -1;
    logic [25:0] d1, d2;
    for (int k = h - 1; k >= 0 && h - k <= 256; k--)
      if (hist[k].slot == s) begin i = k; break; end
    if (i >= 0)
      for (int k = i - 1; k >= 0 && h - k <= 256; k--)
        if (hist[k].slot == s) begin j = k; break; end
    if (i >= 0 && j >= 0) begin
      d1 = line - hist[i].line;
      d2 = hist[i].line - hist[j].line;
      if (d1 == d2 && d1 != '0)
        for (int k = 0; k < int'(deg); k++)
          pend.push_back(line + d1 * 26'(int'(la) + k));
    end
    hist.push_back('{slot: s, line: line});
  endfunction

  always @(posedge clk) begin
    bit wasIdle;
    if (!rstN) begin
      hist.delete();
      pend.delete();
    end else begin
      wasIdle = (pend.size() == 0);
      if (!wasIdle && pfReady) void'(pend.pop_front());
      if (accValid && wasIdle) modelAccess(accPc, accLine, cfgLookahead, cfgDegree);
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    bit expValid;
    if (rstN && !finished) begin
      expValid = (pend.size() != 0);
      compared++;
      if (accReady !== !expValid) begin
        mismatched++;
        $display("FAIL R8: accReady actual %0b expected %0b", accReady, !expValid);
      end else if (pfValid !== expValid) begin
        mismatched++;
        $display("FAIL %s: pfValid actual %0b expected %0b", curReq, pfValid, expValid);
      end else if (expValid && pfLine !== pend[0]) begin
        mismatched++;
        $display("FAIL %s: pfLine actual %0h expected %0h", curReq, pfLine, pend[0]);
      end
    end
  end

  always @(negedge clk) pfReady = stallMode ? ($urandom_range(0, 3) != 0) : 1'b1;

  task automatic doAccess(input logic [31:0] pc, input logic [25:0] line);
    while (!accReady) @(negedge clk);
    accValid = 1'b1; accPc = pc; accLine = line;
    @(negedge clk);
    accValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fillers(input int n);
    for (int k = 0; k < n; k++) doAccess(32'h60 + 32'(k % 4), 26'(k * k + 7));
  endtask

  task automatic endRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    endRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    curReq = "R1"; idle(3);                        // reset state
    curReq = "R3"; doAccess(32'h10, 26'd100); doAccess(32'h10, 26'd104);
    idle(2);
    curReq = "R6"; doAccess(32'h10, 26'd108); idle(8);   // 124,128,132,136
    curReq = "R4"; doAccess(32'h20, 26'd200); doAccess(32'h20, 26'd203);
    doAccess(32'h20, 26'd210); idle(3);
    curReq = "R5"; doAccess(32'h21, 26'd300); doAccess(32'h21, 26'd300);
    doAccess(32'h21, 26'd300); idle(3);
    curReq = "R11"; doAccess(32'h22, 26'd1000); doAccess(32'h22, 26'd990);
    doAccess(32'h22, 26'd980); idle(8);
    curReq = "R2"; doAccess(32'h31, 26'd10); doAccess(32'h32, 26'd500);
    doAccess(32'h31, 26'd20); doAccess(32'h32, 26'd501);
    doAccess(32'h31, 26'd30); doAccess(32'h32, 26'd502); idle(8);
    doAccess(32'h33, 26'd50); doAccess(32'h0001_0133, 26'd60);
    doAccess(32'h33, 26'd70); idle(8);
    curReq = "R7"; stallMode = 1'b1; cfgDegree = 3'd6;
    doAccess(32'h34, 26'd7); doAccess(32'h34, 26'd10); doAccess(32'h34, 26'd13);
    idle(30); stallMode = 1'b0;
    curReq = "R9"; cfgDegree = 3'd4; cfgLookahead = 3'd4;
    doAccess(32'h35, 26'd40); doAccess(32'h35, 26'd42); doAccess(32'h35, 26'd44);
    cfgLookahead = 3'd7; cfgDegree = 3'd1; idle(8);
    cfgDegree = 3'd0; doAccess(32'h35, 26'd46); idle(3);
    cfgLookahead = 3'd0; cfgDegree = 3'd2; doAccess(32'h35, 26'd48); idle(4);
    cfgLookahead = 3'd4; cfgDegree = 3'd4;
    curReq = "R10"; doAccess(32'h40, 26'd2000); doAccess(32'h40, 26'd2001);
    fillers(255); doAccess(32'h40, 26'd2002); idle(4);
    doAccess(32'h41, 26'd3000); doAccess(32'h41, 26'd3005);
    fillers(254); doAccess(32'h41, 26'd3010); idle(8);
    curReq = "R4"; stallMode = 1'b1;
    for (int k = 0; k < 400; k++) begin
      int p = $urandom_range(0, 5);
      doAccess(32'h70 + 32'(p), 26'(1000 * p + ((k / 6) * (p + 1)) + ($urandom_range(0, 7) == 0 ? 3 : 0)));
      if (k % 50 == 0) begin cfgLookahead = 3'($urandom); cfgDegree = 3'($urandom); end
    end
    stallMode = 1'b0; idle(20);
    endRun();
  end
endmodule